// File: doc/BRIEF.md
# Clock-Recovery Link Training Sequencer

This block runs the clock-recovery phase of link training for a display link source with one or two lanes. After a start pulse it drives a short series of register accesses through a generic request/response channel. It sets the link rate, lane count and training pattern, then reads the sink's read-interval code and writes each lane's initial drive byte. From then on it loops: it waits the interval, reads the lane status, and either finishes or reads the sink's adjustment request and rewrites the lane drive bytes from it.

The loop ends with a pass when every active lane reports lock. It ends with a fail on any of three conditions: a lane is already at top swing without lock, the sink keeps asking for the drive already in use, or the iteration budget runs out. Either way, training is switched off with a final write. A one-cycle done pulse follows, and the pass flag is valid with it. The swing and pre-emphasis levels in use stay visible on the outputs.

Top module: `lt_cr_seq`

## Requirements
- R1: Under reset, aux_req, done and pass are low and every lane's swing and pre-emphasis output is 0.
- R2: A start pulse in idle produces, in this order: write 0x0A to 0x00100, write (0x80 | LANES) to 0x00101, write 0x21 to 0x00102, read 0x0000E, then the lane drive writes.
- R3: A transaction holds aux_req with unchanged aux_addr, aux_wr and aux_wdata until the cycle aux_done is seen. aux_req is then low for at least one cycle. Read data is taken in the aux_done cycle.
- R4: The wait starts at the aux_done of the last lane write. An interval code of 0 gives TICKS=CLK_FREQ_KHZ/10 cycles. A code n from 1 to 4 gives n*40*TICKS cycles, and codes above 4 count as 4. The status read request appears W+1 cycles after that aux_done.
- R5: After each wait, 0x00202 is read. Clock recovery passes when bit 0 is set, and also bit 4 when two lanes are active.
- R6: Without a pass, 0x00206 is read. Lane 0 takes bits 3:0 and lane 1 takes bits 7:4. In each nibble, bits 1:0 are the swing level and bits 3:2 the pre-emphasis level.
- R7: Lane drive bytes go to 0x00103 (lane 0) then 0x00104 (lane 1). Each byte is swing in bits 1:0, bit 2 set when swing is 3, pre-emphasis in bits 4:3, and bit 5 set when pre-emphasis is 3. The first write of a run uses level 0.
- R8: If any active lane's swing in use is 3 when lock is missing, the run fails without another lane write.
- R9: The run fails when the request equals the drive in use on 5 consecutive iterations.
- R10: The run fails after 10 iterations without a pass, counting adjust reads.
- R11: Every run ends by writing 0x00 to 0x00102. The next cycle raises done for exactly one cycle, and pass is high in that cycle only if R5's condition was met.
- R12: lane_swing and lane_pre show the levels last written to the sink and hold them after done.
- R13: A start pulse while a run is in progress has no effect on the transaction stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (ignored unless idle) |
| aux_req | output | 1 | Transaction request, held until aux_done |
| aux_wr | output | 1 | 1 = write, 0 = read |
| aux_addr | output | 20 | Sink register address |
| aux_wdata | output | 8 | Write data |
| aux_done | input | 1 | Transaction complete, one cycle |
| aux_rdata | input | 8 | Read data, valid with aux_done |
| done | output | 1 | Run finished, one-cycle pulse |
| pass | output | 1 | Clock recovery achieved, valid with done |
| lane_swing | output | 2*LANES | Swing level per lane, lane 0 in the low bits |
| lane_pre | output | 2*LANES | Pre-emphasis level per lane, lane 0 in the low bits |

## Verification
The assertions assume the channel responder raises aux_done for one cycle only, and only while aux_req is high, with aux_rdata valid in that same cycle. They also assume start is a pulse. The bench's responder keeps to this. It accepts a request only when idle, answers after zero to two cycles of varied latency, and drops aux_done the next cycle. Status and adjust values come from scripted queues, so the pass, stall, top-swing and iteration-limit exits are each reached deliberately.

// File: rtl/lt_cr_pkg.sv
package lt_cr_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_RATE, S_LCNT, S_TPS, S_INTV, S_LANE0, S_LANE1,
        S_WAIT, S_STAT, S_ADJ, S_EVAL, S_OFF, S_DONE
    } seq_state_e;

    // Nibble layout of one lane's request: pre-emphasis above swing
    typedef struct packed {
        logic [1:0] pre;
        logic [1:0] swing;
    } drive_t;

    localparam logic [19:0] ADDR_RATE  = 20'h00100;
    localparam logic [19:0] ADDR_LCNT  = 20'h00101;
    localparam logic [19:0] ADDR_TPS   = 20'h00102;
    localparam logic [19:0] ADDR_LANE0 = 20'h00103;
    localparam logic [19:0] ADDR_LANE1 = 20'h00104;
    localparam logic [19:0] ADDR_INTV  = 20'h0000E;
    localparam logic [19:0] ADDR_STAT  = 20'h00202;
    localparam logic [19:0] ADDR_ADJ   = 20'h00206;

    localparam logic [7:0] RATE_CODE  = 8'h0A;
    localparam logic [7:0] ENH_FRAME  = 8'h80;
    localparam logic [7:0] TPS_CR     = 8'h21;
    localparam logic [7:0] TPS_OFF    = 8'h00;

    function automatic drive_t nib_to_drive(input logic [3:0] n);
        return drive_t'(n);
    endfunction

    function automatic logic [7:0] pack_lane(input drive_t d);
        return {2'b00, (d.pre == 2'd3), d.pre, (d.swing == 2'd3), d.swing};
    endfunction

    function automatic logic is_txn(input seq_state_e s);
        return s inside {S_RATE, S_LCNT, S_TPS, S_INTV, S_LANE0, S_LANE1,
                         S_STAT, S_ADJ, S_OFF};
    endfunction

endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
    parameter int TICKS_100US = 25000,
    parameter int MAX_CODE    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] code,
    output logic       expired
);
    localparam int STEP_4MS = 40 * TICKS_100US;
    localparam int MAX_WAIT = MAX_CODE * STEP_4MS;
    localparam int CW       = $clog2(MAX_WAIT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_val;
    logic          run_q;
    int            n_clamp;

    always_comb begin
        n_clamp  = (code > 8'(MAX_CODE)) ? MAX_CODE : int'(code);
        load_val = (code == 8'd0) ? CW'(TICKS_100US - 1)
                                  : CW'(n_clamp * STEP_4MS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);

    // R4
    expire_once_chk: assert property (@(posedge clk) disable iff (rst)
        expired && !load |=> !expired);

endmodule

// File: rtl/lt_lane_drive.sv
module lt_lane_drive
    import lt_cr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load,
    input  logic [3:0] req_nib,
    output drive_t     lvl,
    output logic [7:0] set_byte,
    output logic       at_max,
    output logic       same
);
    drive_t lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clr) lvl_q <= '0;
        else if (load)  lvl_q <= nib_to_drive(req_nib);
    end

    assign lvl      = lvl_q;
    assign set_byte = pack_lane(lvl_q);
    assign at_max   = (lvl_q.swing == 2'd3);
    assign same     = (nib_to_drive(req_nib) == lvl_q);

endmodule

// File: rtl/lt_stall_track.sv
module lt_stall_track #(
    parameter int STALL_LIMIT = 5,
    parameter int MAX_ITER    = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic same,
    output logic stall_hit,
    output logic iter_hit
);
    localparam int RW = $clog2(STALL_LIMIT + 1);
    localparam int IW = $clog2(MAX_ITER + 1);

    logic [RW-1:0] run_q;
    logic [IW-1:0] iter_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q  <= '0;
            iter_q <= '0;
        end else if (step) begin
            run_q  <= same ? run_q + 1'b1 : '0;
            iter_q <= iter_q + 1'b1;
        end
    end

    assign stall_hit = same && (int'(run_q) + 1 >= STALL_LIMIT);
    assign iter_hit  = (int'(iter_q) + 1 >= MAX_ITER);

    // R10
    iter_budget_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> int'(iter_q) < MAX_ITER);

    // R9
    stall_budget_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> int'(run_q) < STALL_LIMIT);

endmodule

// File: rtl/lt_cr_seq.sv
module lt_cr_seq
    import lt_cr_pkg::*;
#(
    parameter int CLK_FREQ_KHZ  = 250000,
    parameter int LANES         = 2,
    parameter int MAX_ITER      = 10,
    parameter int STALL_LIMIT   = 5,
    parameter int MAX_INTV_CODE = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               aux_req,
    output logic               aux_wr,
    output logic [19:0]        aux_addr,
    output logic [7:0]         aux_wdata,
    input  logic               aux_done,
    input  logic [7:0]         aux_rdata,
    output logic               done,
    output logic               pass,
    output logic [2*LANES-1:0] lane_swing,
    output logic [2*LANES-1:0] lane_pre
);
    localparam int TICKS_100US = CLK_FREQ_KHZ / 10;

    seq_state_e state_q, state_d;
    logic       gap_q;
    logic [7:0] intv_q;
    logic [7:0] adj_q;
    logic       pass_q, pass_d;
    logic       cr_ok;

    logic timer_load, expired;
    logic lane_clr, lane_load;
    logic trk_clr, trk_step, stall_hit, iter_hit;

    drive_t             lvl   [LANES];
    logic [7:0]         set_b [LANES];
    logic [LANES-1:0]   max_v, same_v;

    // Per-lane drive registers
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lt_lane_drive u_lane (
            .clk      (clk),
            .rst      (rst),
            .clr      (lane_clr),
            .load     (lane_load),
            .req_nib  (adj_q[4*i +: 4]),
            .lvl      (lvl[i]),
            .set_byte (set_b[i]),
            .at_max   (max_v[i]),
            .same     (same_v[i])
        );
        assign lane_swing[2*i +: 2] = lvl[i].swing;
        assign lane_pre[2*i +: 2]   = lvl[i].pre;
    end

    lt_wait_timer #(
        .TICKS_100US (TICKS_100US),
        .MAX_CODE    (MAX_INTV_CODE)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .code    (intv_q),
        .expired (expired)
    );

    lt_stall_track #(
        .STALL_LIMIT (STALL_LIMIT),
        .MAX_ITER    (MAX_ITER)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .clr       (trk_clr),
        .step      (trk_step),
        .same      (&same_v),
        .stall_hit (stall_hit),
        .iter_hit  (iter_hit)
    );

    // Lock check over active lanes
    always_comb begin
        cr_ok = 1'b1;
        for (int i = 0; i < LANES; i++)
            if (!aux_rdata[4*i]) cr_ok = 1'b0;
    end

    // Sequencing
    always_comb begin
        state_d    = state_q;
        pass_d     = pass_q;
        timer_load = 1'b0;
        lane_clr   = 1'b0;
        lane_load  = 1'b0;
        trk_clr    = 1'b0;
        trk_step   = 1'b0;
        case (state_q)
            S_IDLE: if (start) begin
                state_d  = S_RATE;
                lane_clr = 1'b1;
                trk_clr  = 1'b1;
                pass_d   = 1'b0;
            end
            S_RATE:  if (aux_done) state_d = S_LCNT;
            S_LCNT:  if (aux_done) state_d = S_TPS;
            S_TPS:   if (aux_done) state_d = S_INTV;
            S_INTV:  if (aux_done) state_d = S_LANE0;
            S_LANE0: if (aux_done) begin
                if (LANES > 1) state_d = S_LANE1;
                else begin
                    state_d    = S_WAIT;
                    timer_load = 1'b1;
                end
            end
            S_LANE1: if (aux_done) begin
                state_d    = S_WAIT;
                timer_load = 1'b1;
            end
            S_WAIT:  if (expired) state_d = S_STAT;
            S_STAT:  if (aux_done) begin
                if (cr_ok) begin
                    pass_d  = 1'b1;
                    state_d = S_OFF;
                end else begin
                    state_d = S_ADJ;
                end
            end
            S_ADJ:   if (aux_done) state_d = S_EVAL;
            S_EVAL: begin
                trk_step = 1'b1;
                if ((|max_v) || stall_hit || iter_hit) begin
                    state_d = S_OFF;
                end else begin
                    lane_load = 1'b1;
                    state_d   = S_LANE0;
                end
            end
            S_OFF:   if (aux_done) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Transaction fields
    always_comb begin
        aux_wr    = 1'b0;
        aux_addr  = '0;
        aux_wdata = '0;
        case (state_q)
            S_RATE:  begin aux_wr = 1'b1; aux_addr = ADDR_RATE;  aux_wdata = RATE_CODE; end
            S_LCNT:  begin aux_wr = 1'b1; aux_addr = ADDR_LCNT;  aux_wdata = ENH_FRAME | 8'(LANES); end
            S_TPS:   begin aux_wr = 1'b1; aux_addr = ADDR_TPS;   aux_wdata = TPS_CR; end
            S_INTV:  aux_addr = ADDR_INTV;
            S_LANE0: begin aux_wr = 1'b1; aux_addr = ADDR_LANE0; aux_wdata = set_b[0]; end
            S_LANE1: begin aux_wr = 1'b1; aux_addr = ADDR_LANE1; aux_wdata = set_b[LANES-1]; end
            S_STAT:  aux_addr = ADDR_STAT;
            S_ADJ:   aux_addr = ADDR_ADJ;
            S_OFF:   begin aux_wr = 1'b1; aux_addr = ADDR_TPS;   aux_wdata = TPS_OFF; end
            default: ;
        endcase
    end

    assign aux_req = is_txn(state_q) && !gap_q;
    assign done    = (state_q == S_DONE);
    assign pass    = done && pass_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            gap_q   <= 1'b0;
            intv_q  <= '0;
            adj_q   <= '0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            gap_q   <= aux_req && aux_done;
            pass_q  <= pass_d;
            if (state_q == S_INTV && aux_done) intv_q <= aux_rdata;
            if (state_q == S_ADJ  && aux_done) adj_q  <= aux_rdata;
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        aux_req && !aux_done |=> aux_req && $stable(aux_addr)
                                 && $stable(aux_wdata) && $stable(aux_wr));

    // R3
    req_gap_chk: assert property (@(posedge clk) disable iff (rst)
        aux_req && aux_done |=> !aux_req);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(aux_done));

endmodule

// File: tb/lt_cr_seq_bench.sv
module lt_cr_seq_bench;
    localparam int KHZ   = 200;
    localparam int TICKS = KHZ / 10;
    localparam int LANES = 2;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic aux_done = 1'b0;
    logic [7:0] aux_rdata = '0;
    logic aux_req, aux_wr, done, pass;
    logic [19:0] aux_addr;
    logic [7:0] aux_wdata;
    logic [2*LANES-1:0] lane_swing, lane_pre;

    always #2 clk = ~clk;

    lt_cr_seq #(.CLK_FREQ_KHZ(KHZ), .LANES(LANES)) u_lt_cr_seq (
        .clk(clk), .rst(rst), .start(start),
        .aux_req(aux_req), .aux_wr(aux_wr), .aux_addr(aux_addr),
        .aux_wdata(aux_wdata), .aux_done(aux_done), .aux_rdata(aux_rdata),
        .done(done), .pass(pass), .lane_swing(lane_swing), .lane_pre(lane_pre)
    );

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    typedef struct { bit wr; int addr; int data; } txn_t;
    txn_t exp_q[$];
    int   st_q[$], aj_q[$];
    int   code_cfg, exp_w;
    bit   exp_pass;
    int   exp_sw[2], exp_pre[2];

    function automatic int lane_byte(input int sw, input int pr);
        return sw | ((sw == 3) ? 4 : 0) | (pr << 3) | ((pr == 3) ? 32 : 0);
    endfunction

    // Behavioural reference of one run
    task automatic build();
        int st[$], aj[$];
        int d_sw[2], d_pre[2], r_sw[2], r_pre[2];
        int run, it, idx, s, a;
        bit same;
        st = st_q; aj = aj_q;
        exp_q.delete();
        exp_q.push_back('{1'b1, 'h100, 'h0A});
        exp_q.push_back('{1'b1, 'h101, 'h80 | LANES});
        exp_q.push_back('{1'b1, 'h102, 'h21});
        exp_q.push_back('{1'b0, 'h00E, 0});
        d_sw = '{0, 0}; d_pre = '{0, 0};
        exp_q.push_back('{1'b1, 'h103, lane_byte(0, 0)});
        exp_q.push_back('{1'b1, 'h104, lane_byte(0, 0)});
        run = 0; it = 0; idx = 0; exp_pass = 0;
        forever begin
            exp_q.push_back('{1'b0, 'h202, 0});
            s = (idx < st.size()) ? st[idx] : 0;
            if ((s & 1) != 0 && (s & 16) != 0) begin exp_pass = 1; break; end
            exp_q.push_back('{1'b0, 'h206, 0});
            a = (idx < aj.size()) ? aj[idx] : 0;
            idx++; it++;
            for (int l = 0; l < 2; l++) begin
                r_sw[l]  = (a >> (4*l)) & 3;
                r_pre[l] = (a >> (4*l + 2)) & 3;
            end
            same = (r_sw[0] == d_sw[0]) && (r_pre[0] == d_pre[0]) &&
                   (r_sw[1] == d_sw[1]) && (r_pre[1] == d_pre[1]);
            run = same ? run + 1 : 0;
            if (d_sw[0] == 3 || d_sw[1] == 3) break;
            if (run >= 5) break;
            if (it >= 10) break;
            d_sw = r_sw; d_pre = r_pre;
            exp_q.push_back('{1'b1, 'h103, lane_byte(d_sw[0], d_pre[0])});
            exp_q.push_back('{1'b1, 'h104, lane_byte(d_sw[1], d_pre[1])});
        end
        exp_q.push_back('{1'b1, 'h102, 0});
        exp_sw = d_sw; exp_pre = d_pre;
        exp_w = (code_cfg == 0) ? TICKS : ((code_cfg > 4) ? 4 : code_cfg) * 40 * TICKS;
    endtask

    function automatic string tag_of(input int addr, input int data);
        if (addr == 'h202) return "R5";
        if (addr == 'h206) return "R6";
        if (addr == 'h103 || addr == 'h104) return "R7";
        if (addr == 'h102 && data == 0) return "R11";
        return "R2";
    endfunction

    // Responder and per-clock monitor
    bit busy = 0, drop = 0, cur_last = 0, done_due = 0, done_seen = 0, pass_seen = 0;
    int lat = 0, rsp = 0, cur_addr = 0, last_lane_cyc = 0, cyc = 0, extra = 0;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                chk(done == done_due, "R11", "done timing", int'(done), int'(done_due));
                if (done) begin done_seen = 1; pass_seen = pass; end
                done_due = 0;
                if (drop) begin
                    aux_done = 0; drop = 0; busy = 0;
                    chk(!aux_req, "R3", "gap after completion", int'(aux_req), 0);
                end else if (busy) begin
                    chk(aux_req && int'(aux_addr) == cur_addr, "R3", "request held",
                        int'(aux_addr), cur_addr);
                    if (lat == 0) begin
                        aux_done = 1; aux_rdata = 8'(rsp); drop = 1;
                        if (cur_last) done_due = 1;
                        if (cur_addr == 'h104) last_lane_cyc = cyc;
                    end else lat--;
                end else if (aux_req) begin
                    int act;
                    act = (int'(aux_wr) << 28) | (int'(aux_addr) << 8) | int'(aux_wdata);
                    if (exp_q.size() == 0) begin
                        extra++;
                        chk(0, "R13", "unexpected transaction", act, 0);
                        cur_last = 0;
                    end else begin
                        txn_t e;
                        e = exp_q.pop_front();
                        chk(aux_wr == e.wr && int'(aux_addr) == e.addr &&
                            (!e.wr || int'(aux_wdata) == e.data), tag_of(e.addr, e.data),
                            "transaction", act, (int'(e.wr) << 28) | (e.addr << 8) | e.data);
                        cur_last = (exp_q.size() == 0);
                    end
                    if (int'(aux_addr) == 'h202)
                        chk(cyc - last_lane_cyc == exp_w + 1, "R4", "wait length",
                            cyc - last_lane_cyc, exp_w + 1);
                    case (int'(aux_addr))
                        'h00E: rsp = code_cfg;
                        'h202: rsp = (st_q.size() > 0) ? st_q.pop_front() : 0;
                        'h206: rsp = (aj_q.size() > 0) ? aj_q.pop_front() : 0;
                        default: rsp = 0;
                    endcase
                    cur_addr = int'(aux_addr);
                    lat = cyc % 3;
                    busy = 1;
                end
            end
        end
    end

    task automatic run_scn(input int code, input string ftag, input bit poke);
        int guard;
        code_cfg = code;
        build();
        done_seen = 0; extra = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        guard = 0;
        while (!done_seen && guard < 40000) begin @(negedge clk); guard++; end
        chk(done_seen, "R11", "run completed", int'(done_seen), 1);
        repeat (3) @(negedge clk);
        chk(pass_seen == exp_pass, ftag, "pass flag", int'(pass_seen), int'(exp_pass));
        for (int l = 0; l < 2; l++) begin
            chk(int'(lane_swing[2*l +: 2]) == exp_sw[l], "R12", "final swing",
                int'(lane_swing[2*l +: 2]), exp_sw[l]);
            chk(int'(lane_pre[2*l +: 2]) == exp_pre[l], "R12", "final pre-emphasis",
                int'(lane_pre[2*l +: 2]), exp_pre[l]);
        end
        chk(exp_q.size() == 0, "R2", "transactions missing", exp_q.size(), 0);
        chk(extra == 0, poke ? "R13" : "R2", "extra transactions", extra, 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!aux_req && !done && !pass, "R1", "control outputs in reset",
            {aux_req, done, pass}, 0);
        rst = 0;
        @(negedge clk);
        chk(lane_swing == 0 && lane_pre == 0, "R1", "levels after reset",
            {lane_swing, lane_pre}, 0);

        // lane 0 locks alone first, then both after one step (R5 pass)
        st_q = '{'h01, 'h11}; aj_q = '{'h11};
        run_scn(0, "R5", 0);
        // stepping requests reach top swing, then stuck (R8), with a late start pulse (R13)
        st_q = '{0, 0, 0, 0}; aj_q = '{'h11, 'h22, 'h33, 'h33};
        run_scn(0, "R8", 1);
        // same request over and over (R9), 8 ms wait
        st_q = '{0, 0, 0, 0, 0}; aj_q = '{0, 0, 0, 0, 0};
        run_scn(2, "R9", 0);
        // alternating requests never settle (R10)
        st_q = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        aj_q = '{'h01, 0, 'h01, 0, 'h01, 0, 'h01, 0, 'h01, 0};
        run_scn(0, "R10", 0);
        // pre-emphasis packing with clamped interval code (R6, R7, R4)
        st_q = '{0, 'h11}; aj_q = '{'h6E};
        run_scn(9, "R6", 0);
        // immediate lock, 4 ms wait
        st_q = '{'h11}; aj_q = '{};
        run_scn(1, "R5", 0);
        // only lane 1 locked at first: not a pass
        st_q = '{'h10, 'h11}; aj_q = '{0};
        run_scn(0, "R5", 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule